// File: doc/BRIEF.md
# LPI Pending Set/Clear Controller

This block holds the pending state of message-style interrupts whose identifiers start at 8192. Software reaches it through a register write port and a combinational read port. It can turn the feature on or off, choose how many identifier bits are in use, and mark single identifiers pending or not pending. The CPU interface reports an acknowledged identifier on a separate input, and that clears the matching pending bit at once. These interrupts have no active state.

The pending state lives in a local byte-organised bitmap, so the block needs no memory master. Each cycle it drives the whole pending vector to the arbiter. Whenever the vector changes, it raises a one-cycle change pulse so the arbiter runs its selection again. Writes that would not change anything are dropped without a pulse: writes while disabled, writes to identifiers outside the implemented range, and writes that set a bit already set or clear a bit already clear.

Top module: `lpi_pend_ctrl`

## Requirements
- R1: After reset the enable bit, the identifier-bits field, every pending bit and `update_o` are all 0.
- R2: With the enable on, a write to offset 0x40 carrying an implemented identifier sets `pending_o[id-8192]`. `update_o` is high for exactly the cycle after the accepting clock edge.
- R3: With the enable on, a write to offset 0x48 carrying an implemented pending identifier clears that bit and raises the same one-cycle pulse.
- R4: While the enable (bit 0 of the register at offset 0x00) is 0, writes to offsets 0x40 and 0x48 leave `pending_o` unchanged and raise no pulse.
- R5: An identifier is implemented only if it is at least 8192, at most 2^(idbits+1)-1, and at most 8192+NUM_LPI-1. Writes naming any other identifier are ignored.
- R6: Setting a bit that is already pending, or clearing one that is not pending, changes nothing and raises no pulse.
- R7: An acknowledge of an implemented identifier clears its pending bit, whatever the enable is, and pulses `update_o` if the bit was set. An acknowledge below 8192 has no effect.
- R8: The identifier-bits field is bits [4:0] of the register at offset 0x70. A written value above 15 is stored as 15. Both registers read back their stored fields.
- R9: An identifier's bit lives in storage byte (id-8192)/8 at bit position id%8. For example, identifier 8201 appears as `pending_o[15:8]` = 0x02.
- R10: When a write and an acknowledge arrive in the same cycle, the write is applied first and the acknowledge second. A set and an acknowledge of the same identifier therefore leave that bit clear.
- R11: Only bits [31:0] of the written data carry the identifier. The upper data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write offset |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read offset |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| ack_valid_i | input | 1 | CPU acknowledge strobe |
| ack_id_i | input | 32 | Acknowledged interrupt identifier |
| pending_o | output | NUM_LPI | Pending vector, bit i is identifier 8192+i |
| update_o | output | 1 | One-cycle pulse when the pending vector changed |

## Verification
A write or acknowledge sampled at one rising edge shows up in `pending_o` one edge later, and `update_o` is high only in the cycle after that edge. Register contents appear on `rd_data_o` in the same cycle as `rd_addr_i`. The bench drives every stimulus on a falling edge and removes it on the next falling edge. It checks the vector and the pulse at that second falling edge, then checks one cycle later that the pulse has dropped. Reads are sampled a short delay after the address is applied.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    localparam logic [31:0] LPI_FIRST_ID = 32'd8192;
    localparam logic [4:0]  IDBITS_CAP   = 5'd15;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SET   = 8'h40;
    localparam logic [7:0] OFS_CLR   = 8'h48;
    localparam logic [7:0] OFS_PROPS = 8'h70;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_SET  = 2'd1,
        PEND_CLR  = 2'd2
    } pend_op_e;

    typedef struct packed {
        logic       en;
        logic [4:0] idbits;
    } lpi_regs_t;

endpackage

// File: rtl/lpi_id_decode.sv
module lpi_id_decode #(
    parameter int unsigned NUM_LPI = 64,
    localparam int unsigned NUM_BYTES = NUM_LPI / 8,
    localparam int unsigned BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic [31:0]       id_i,
    input  logic [4:0]        idbits_i,
    output logic              hit_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [7:0]        mask_o
);
    import lpi_pkg::*;

    localparam logic [31:0] LAST_ID = LPI_FIRST_ID + 32'(NUM_LPI) - 32'd1;

    logic [32:0] id_limit;
    logic [31:0] offset;
    logic        unused_ofs;

    always_comb begin
        id_limit = (33'd1 << (6'(idbits_i) + 6'd1)) - 33'd1;
        offset   = id_i - LPI_FIRST_ID;
        hit_o    = (id_i >= LPI_FIRST_ID) && (id_i <= LAST_ID) &&
                   ({1'b0, id_i} <= id_limit);
        byte_o   = offset[BYTE_W+2:3];
        mask_o   = 8'd1 << offset[2:0];
    end

    assign unused_ofs = ^offset[31:BYTE_W+3];

endmodule

// File: rtl/lpi_pend_bank.sv
module lpi_pend_bank #(
    parameter int unsigned NUM_LPI = 64,
    localparam int unsigned NUM_BYTES = NUM_LPI / 8,
    localparam int unsigned BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  lpi_pkg::pend_op_e  wr_op_i,
    input  logic [BYTE_W-1:0]  wr_byte_i,
    input  logic [7:0]         wr_mask_i,
    input  logic               ack_i,
    input  logic [BYTE_W-1:0]  ack_byte_i,
    input  logic [7:0]         ack_mask_i,
    output logic [NUM_LPI-1:0] pending_o,
    output logic               update_o
);
    import lpi_pkg::*;

    typedef struct packed {
        logic [NUM_BYTES-1:0][7:0] bytes;
        logic                      upd;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        bank_d.upd = 1'b0;
        case (wr_op_i)
            PEND_SET: bank_d.bytes[wr_byte_i] = bank_q.bytes[wr_byte_i] | wr_mask_i;
            PEND_CLR: bank_d.bytes[wr_byte_i] = bank_q.bytes[wr_byte_i] & ~wr_mask_i;
            default:  ;
        endcase
        // acknowledge is applied after the register write
        if (ack_i) begin
            bank_d.bytes[ack_byte_i] = bank_d.bytes[ack_byte_i] & ~ack_mask_i;
        end
        bank_d.upd = (bank_d.bytes != bank_q.bytes);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pending_o = bank_q.bytes;
    assign update_o  = bank_q.upd;

endmodule

// File: rtl/lpi_pend_ctrl.sv
module lpi_pend_ctrl #(
    parameter int unsigned NUM_LPI = 64,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 64,
    localparam int unsigned NUM_BYTES = NUM_LPI / 8,
    localparam int unsigned BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic               ack_valid_i,
    input  logic [31:0]        ack_id_i,
    output logic [NUM_LPI-1:0] pending_o,
    output logic               update_o
);
    import lpi_pkg::*;

    lpi_regs_t regs_d, regs_q;
    pend_op_e  wr_op;
    logic      ack_take;
    logic      lpi_en;
    logic [4:0] lpi_idbits;
    logic      unused_hi;

    // decoder 0 serves the write data, decoder 1 the acknowledge
    logic [1:0][31:0]       dec_id;
    logic [1:0]             dec_hit;
    logic [1:0][BYTE_W-1:0] dec_byte;
    logic [1:0][7:0]        dec_mask;

    assign dec_id[0] = wr_data_i[31:0];
    assign dec_id[1] = ack_id_i;

    for (genvar g = 0; g < 2; g++) begin : g_dec
        lpi_id_decode #(.NUM_LPI(NUM_LPI)) u_dec (
            .id_i     (dec_id[g]),
            .idbits_i (regs_q.idbits),
            .hit_o    (dec_hit[g]),
            .byte_o   (dec_byte[g]),
            .mask_o   (dec_mask[g])
        );
    end

    always_comb begin
        regs_d   = regs_q;
        wr_op    = PEND_NONE;
        ack_take = ack_valid_i && dec_hit[1];
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_W'(OFS_CTRL)) begin
                regs_d.en = wr_data_i[0];
            end else if (wr_addr_i == ADDR_W'(OFS_PROPS)) begin
                regs_d.idbits = (wr_data_i[4:0] > IDBITS_CAP) ? IDBITS_CAP : wr_data_i[4:0];
            end else if (wr_addr_i == ADDR_W'(OFS_SET) && regs_q.en && dec_hit[0]) begin
                wr_op = PEND_SET;
            end else if (wr_addr_i == ADDR_W'(OFS_CLR) && regs_q.en && dec_hit[0]) begin
                wr_op = PEND_CLR;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(OFS_CTRL)) begin
            rd_data_o = DATA_W'(regs_q.en);
        end else if (rd_addr_i == ADDR_W'(OFS_PROPS)) begin
            rd_data_o = DATA_W'(regs_q.idbits);
        end
    end

    lpi_pend_bank #(.NUM_LPI(NUM_LPI)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_op_i    (wr_op),
        .wr_byte_i  (dec_byte[0]),
        .wr_mask_i  (dec_mask[0]),
        .ack_i      (ack_take),
        .ack_byte_i (dec_byte[1]),
        .ack_mask_i (dec_mask[1]),
        .pending_o  (pending_o),
        .update_o   (update_o)
    );

    assign lpi_en     = regs_q.en;
    assign lpi_idbits = regs_q.idbits;
    assign unused_hi  = ^wr_data_i[DATA_W-1:32];

endmodule

// File: rtl/lpi_pend_ctrl_chk.sv
module lpi_pend_ctrl_chk #(
    parameter int unsigned NUM_LPI = 64,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic               ack_valid_i,
    input logic [31:0]        ack_id_i,
    input logic [NUM_LPI-1:0] pending_o,
    input logic               update_o,
    input logic               lpi_en,
    input logic [4:0]         lpi_idbits
);
    import lpi_pkg::*;

    localparam logic [31:0] LAST_ID = LPI_FIRST_ID + 32'(NUM_LPI) - 32'd1;

    logic pend_wr;
    logic unused_chk;
    assign pend_wr = wr_en_i && (wr_addr_i == ADDR_W'(OFS_SET) || wr_addr_i == ADDR_W'(OFS_CLR));
    assign unused_chk = ^wr_data_i[DATA_W-1:32];

    p_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_wr && !lpi_en && !ack_valid_i |=> !update_o && $stable(pending_o));

    p_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_wr && (wr_data_i[31:0] > LAST_ID) && !ack_valid_i |=> $stable(pending_o) && !update_o);

    p_pulse_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        update_o |-> (pending_o != $past(pending_o)));

    p_quiet_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pending_o == $past(pending_o)) |-> !update_o);

    p_low_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_i && (ack_id_i < LPI_FIRST_ID) && !wr_en_i |=> $stable(pending_o));

    p_idbits_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lpi_idbits <= IDBITS_CAP);

endmodule

bind lpi_pend_ctrl lpi_pend_ctrl_chk #(
    .NUM_LPI (NUM_LPI),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .ack_valid_i (ack_valid_i),
    .ack_id_i    (ack_id_i),
    .pending_o   (pending_o),
    .update_o    (update_o),
    .lpi_en      (lpi_en),
    .lpi_idbits  (lpi_idbits)
);

// File: tb/test_lpi_pend_ctrl.sv
module test_lpi_pend_ctrl;

    localparam int NUM_LPI = 64;
    localparam logic [31:0] B = 32'd8192;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [7:0]  rd_addr_i = '0;
    logic [63:0] rd_data_o;
    logic        ack_valid_i = 1'b0;
    logic [31:0] ack_id_i = '0;
    logic [63:0] pending_o;
    logic        update_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [63:0] exp_p = '0;

    always #4 clk = ~clk;

    lpi_pend_ctrl i_lpi_pend_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .ack_valid_i(ack_valid_i), .ack_id_i(ack_id_i),
        .pending_o(pending_o), .update_o(update_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the falling edge after the capturing edge
    task automatic step(input bit we, input logic [7:0] a, input logic [63:0] d,
                        input bit av, input logic [31:0] aid);
        @(negedge clk);
        wr_en_i = we; wr_addr_i = a; wr_data_i = d;
        ack_valid_i = av; ack_id_i = aid;
        @(negedge clk);
        wr_en_i = 1'b0; ack_valid_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        step(1'b1, a, d, 1'b0, '0);
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [63:0] exp);
        @(negedge clk);
        rd_addr_i = a;
        #1;
        chk(tag, rd_data_o, exp);
    endtask

    task automatic after(input string tag, input bit exp_upd);
        chk({tag, " pending"}, pending_o, exp_p);
        chk({tag, " update"}, 64'(update_o), 64'(exp_upd));
        @(negedge clk);
        chk({tag, " update drop"}, 64'(update_o), 64'd0);
    endtask

    task automatic t_reset;
        rd("R1 ctrl", 8'h00, 64'd0);
        rd("R1 props", 8'h70, 64'd0);
        chk("R1 pending", pending_o, 64'd0);
        chk("R1 update", 64'(update_o), 64'd0);
    endtask

    task automatic t_config;
        wr(8'h70, 64'h1F);
        rd("R8 clamp", 8'h70, 64'd15);
        wr(8'h70, 64'd13);
        rd("R8 idbits", 8'h70, 64'd13);
    endtask

    task automatic t_disabled;
        wr(8'h40, 64'(B));
        after("R4 set while off", 1'b0);
        wr(8'h00, 64'd1);
        rd("R4 enable readback", 8'h00, 64'd1);
    endtask

    task automatic t_set;
        wr(8'h40, 64'(B));
        exp_p[0] = 1'b1;
        after("R2 set", 1'b1);
        wr(8'h40, 64'(B + 32'd9));
        exp_p[9] = 1'b1;
        after("R9 set id 8201", 1'b1);
        chk("R9 byte 1", 64'(pending_o[15:8]), 64'h02);
    endtask

    task automatic t_redundant;
        wr(8'h40, 64'(B));
        after("R6 set again", 1'b0);
        wr(8'h48, 64'(B + 32'd5));
        after("R6 clear idle", 1'b0);
    endtask

    task automatic t_clear;
        wr(8'h48, 64'(B));
        exp_p[0] = 1'b0;
        after("R3 clear", 1'b1);
    endtask

    task automatic t_range;
        wr(8'h40, 64'(B + 32'd64));
        after("R5 beyond storage", 1'b0);
        wr(8'h40, 64'(B - 32'd1));
        after("R5 below base", 1'b0);
        wr(8'h70, 64'd12);
        wr(8'h40, 64'(B + 32'd8));
        after("R5 beyond idbits", 1'b0);
        wr(8'h70, 64'd13);
    endtask

    task automatic t_upper;
        wr(8'h40, {32'hDEAD_BEEF, B + 32'd3});
        exp_p[3] = 1'b1;
        after("R11 upper bits", 1'b1);
    endtask

    task automatic t_ack;
        step(1'b0, '0, '0, 1'b1, B + 32'd3);
        exp_p[3] = 1'b0;
        after("R7 ack", 1'b1);
        wr(8'h00, 64'd0);
        step(1'b0, '0, '0, 1'b1, B + 32'd9);
        exp_p[9] = 1'b0;
        after("R7 ack while off", 1'b1);
        step(1'b0, '0, '0, 1'b1, 32'd100);
        after("R7 ack low id", 1'b0);
        wr(8'h00, 64'd1);
    endtask

    task automatic t_same;
        step(1'b1, 8'h40, 64'(B + 32'd20), 1'b1, B + 32'd20);
        after("R10 set and ack same id", 1'b0);
        wr(8'h40, 64'(B + 32'd30));
        exp_p[30] = 1'b1;
        after("R10 prepare", 1'b1);
        step(1'b1, 8'h40, 64'(B + 32'd31), 1'b1, B + 32'd30);
        exp_p[31] = 1'b1;
        exp_p[30] = 1'b0;
        after("R10 set and ack differ", 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        t_reset();
        t_config();
        t_disabled();
        t_set();
        t_redundant();
        t_clear();
        t_range();
        t_upper();
        t_ack();
        t_same();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule